// File: doc/BRIEF.md
# Misaligned Access Exception Unit

This unit sits beside the load/store path of a processor pipeline. Each cycle it may receive one decoded memory request: the access class, the effective address and the address of the instruction. If the address does not suit the access size, the unit blocks the memory access and raises an address exception. It then performs the exception entry. It saves three status bits (supervisor mode, interrupt enable, carry) into backup copies. It clears the interrupt enable and carry bits and leaves the mode bit as it was. It records the faulting instruction's own address and sends the core to a fixed handler vector.

When the handler ends with a return-from-exception strobe, the unit puts back the three status bits. It also supplies a resume address: the saved instruction address with its two low bits cleared, so the core always resumes on a word boundary. An external interrupt request that arrives in the same cycle as a detected misalignment is not accepted in that cycle. The exception takes priority, and the requester keeps its line asserted.

Status bits travel as a 3-bit vector: bit 2 is SM (supervisor mode), bit 1 is IE (interrupt enable), bit 0 is C (carry). The access class is coded 2'b00 no memory access, 2'b01 byte, 2'b10 halfword (signed or unsigned load, store), 2'b11 word (load, store, lock, unlock).

Top module: `maexc_unit`

## Requirements
- R1: For a valid halfword request (class 2'b10), address bits [1:0] of 01 or 11 are a fault, and 00 or 10 are legal.
- R2: For a valid word request (class 2'b11), any nonzero value of address bits [1:0] is a fault.
- R3: Byte requests (2'b01), no-memory requests (2'b00) and cycles with `req_valid_i` low never fault, whatever the address.
- R4: `mem_en_o` is high in the same cycle for a valid, legal request whose class is not 2'b00, and low otherwise (a faulting access never reaches memory).
- R5: `irq_accept_o` equals `irq_req_i` except in a cycle with a fault, where it is low.
- R6: The cycle after a fault, `exc_taken_o` and `psw_wr_o` are high for that one cycle and `next_pc_o` equals parameter `VEC_ADDR`.
- R7: On entry, `bpsw_o` takes the `psw_i` value of the fault cycle, and `psw_o` becomes {SM unchanged, IE=0, C=0}.
- R8: On entry, `bpc_o` takes the `pc_i` of the faulting instruction itself, so `bpc_o[1]` is 1 for an instruction off a word boundary and 0 for one on it.
- R9: The cycle after `rte_i` (with no fault that cycle), `rte_done_o` and `psw_wr_o` pulse and `next_pc_o` equals `bpc_o` with bits [1:0] forced to 00.
- R10: On that return, `psw_o` takes the value of `bpsw_o`.
- R11: If a fault and `rte_i` occur in the same cycle, only the exception entry takes place.
- R12: After reset, every registered output is zero and the pulses are low; `next_pc_o` and `psw_o` hold their values between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| req_kind_i | input | 2 | Access class |
| ea_i | input | AW | Effective address |
| pc_i | input | AW | Address of the requesting instruction |
| psw_i | input | 3 | Current {SM, IE, C} |
| irq_req_i | input | 1 | External interrupt request |
| rte_i | input | 1 | Return-from-exception strobe |
| mem_en_o | output | 1 | Memory access permitted |
| irq_accept_o | output | 1 | Interrupt accepted this cycle |
| exc_taken_o | output | 1 | Exception entry pulse |
| rte_done_o | output | 1 | Return pulse |
| psw_wr_o | output | 1 | Core must load `psw_o` |
| psw_o | output | 3 | New {SM, IE, C} |
| bpsw_o | output | 3 | Backup {SM, IE, C} |
| bpc_o | output | AW | Backup PC |
| next_pc_o | output | AW | PC to load: handler vector or resume address |

## Verification
The assertions assume the core presents a request together with its instruction address in one cycle. They also assume `rte_i` is a single-cycle strobe that comes only after an entry, so the backup registers hold meaningful contents. The stimulus drives every input on the falling edge and holds it for one full cycle. It issues returns only after a fault has loaded the backups, except for one deliberate clash of return and fault in the same cycle. Addresses and status values are chosen so that each low-bit pattern and each status combination is distinguishable in the saved copies.

// File: rtl/maexc_pkg.sv
package maexc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_BYTE = 2'b01,
    ACC_HALF = 2'b10,
    ACC_WORD = 2'b11
  } acc_kind_e;

  localparam int PSW_W = 3;

  typedef struct packed {
    logic sm;
    logic ie;
    logic c;
  } psw_t;

  function automatic logic [1:0] align_mask(acc_kind_e k);
    case (k)
      ACC_HALF: align_mask = 2'b01;
      ACC_WORD: align_mask = 2'b11;
      default:  align_mask = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/maexc_align_chk.sv
module maexc_align_chk
  import maexc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_kind_i,
  input  logic [AW-1:0] ea_i,
  output logic          fault_o,
  output logic          mem_en_o
);
  acc_kind_e kind;
  logic [1:0] mask;
  logic       misalign;
  logic       is_mem;

  assign kind     = acc_kind_e'(req_kind_i);
  assign mask     = align_mask(kind);
  assign misalign = |(ea_i[1:0] & mask);
  assign is_mem   = (kind != ACC_NONE);
  assign fault_o  = req_valid_i & misalign;
  assign mem_en_o = req_valid_i & is_mem & ~misalign;

  p_half_odd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'b10 && ea_i[0]) |-> !mem_en_o);
  p_half_even_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'b10 && !ea_i[0]) |-> mem_en_o);
  p_word_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'b11 && ea_i[1:0] != 2'b00) |-> fault_o);
  p_byte_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || req_kind_i[1] == 1'b0) |-> !fault_o);
  p_no_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && mem_en_o));
endmodule

// File: rtl/maexc_ctx_regs.sv
module maexc_ctx_regs
  import maexc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [PSW_W-1:0] psw_i,
  output logic [AW-1:0]    bpc_o,
  output logic [PSW_W-1:0] bpsw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bpc_o  <= '0;
      bpsw_o <= '0;
    end else if (capture_i) begin
      bpc_o  <= pc_i;
      bpsw_o <= psw_i;
    end
  end

  p_bpc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> bpc_o == $past(pc_i));
  p_bpsw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> bpsw_o == $past(psw_i));
  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(bpc_o));
endmodule

// File: rtl/maexc_entry_ctl.sv
module maexc_entry_ctl
  import maexc_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [AW-1:0] VEC_ADDR = 32'h0000_0080
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_i,
  input  logic             rte_i,
  input  logic [PSW_W-1:0] psw_i,
  input  logic [AW-1:0]    bpc_i,
  input  logic [PSW_W-1:0] bpsw_i,
  output logic             exc_taken_o,
  output logic             rte_done_o,
  output logic             psw_wr_o,
  output logic [PSW_W-1:0] psw_o,
  output logic [AW-1:0]    next_pc_o
);
  psw_t cur_psw, entry_psw;
  logic rte_go;
  logic [AW-1:0] resume_pc;

  assign cur_psw   = psw_t'(psw_i);
  assign rte_go    = rte_i & ~fault_i;  // exception outranks return
  assign resume_pc = {bpc_i[AW-1:2], 2'b00};

  always_comb begin
    entry_psw    = cur_psw;
    entry_psw.ie = 1'b0;
    entry_psw.c  = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_taken_o <= 1'b0;
      rte_done_o  <= 1'b0;
      psw_o       <= '0;
      next_pc_o   <= '0;
    end else begin
      exc_taken_o <= fault_i;
      rte_done_o  <= rte_go;
      if (fault_i) begin
        psw_o     <= entry_psw;
        next_pc_o <= VEC_ADDR;
      end else if (rte_go) begin
        psw_o     <= bpsw_i;
        next_pc_o <= resume_pc;
      end
    end
  end

  assign psw_wr_o = exc_taken_o | rte_done_o;

  p_vec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_taken_o |-> next_pc_o == VEC_ADDR);
  p_entry_psw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> psw_o[1:0] == 2'b00 && psw_o[2] == $past(psw_i[2]));
  p_resume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rte_done_o |-> next_pc_o[1:0] == 2'b00);
  p_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rte_i && !fault_i) |=> psw_o == $past(bpsw_i));
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exc_taken_o && rte_done_o));
endmodule

// File: rtl/maexc_unit.sv
module maexc_unit
  import maexc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] VEC_ADDR = 32'h0000_0080
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_kind_i,
  input  logic [AW-1:0] ea_i,
  input  logic [AW-1:0] pc_i,
  input  logic [2:0]    psw_i,
  input  logic          irq_req_i,
  input  logic          rte_i,
  output logic          mem_en_o,
  output logic          irq_accept_o,
  output logic          exc_taken_o,
  output logic          rte_done_o,
  output logic          psw_wr_o,
  output logic [2:0]    psw_o,
  output logic [2:0]    bpsw_o,
  output logic [AW-1:0] bpc_o,
  output logic [AW-1:0] next_pc_o
);
  logic fault;

  maexc_align_chk #(.AW(AW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .ea_i        (ea_i),
    .fault_o     (fault),
    .mem_en_o    (mem_en_o)
  );

  maexc_ctx_regs #(.AW(AW)) u_ctx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (fault),
    .pc_i      (pc_i),
    .psw_i     (psw_i),
    .bpc_o     (bpc_o),
    .bpsw_o    (bpsw_o)
  );

  maexc_entry_ctl #(.AW(AW), .VEC_ADDR(VEC_ADDR)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_i     (fault),
    .rte_i       (rte_i),
    .psw_i       (psw_i),
    .bpc_i       (bpc_o),
    .bpsw_i      (bpsw_o),
    .exc_taken_o (exc_taken_o),
    .rte_done_o  (rte_done_o),
    .psw_wr_o    (psw_wr_o),
    .psw_o       (psw_o),
    .next_pc_o   (next_pc_o)
  );

  assign irq_accept_o = irq_req_i & ~fault;

  p_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !irq_accept_o) |=> exc_taken_o);
  p_taken_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i[1] && !mem_en_o) |=> exc_taken_o && psw_wr_o);
endmodule

// File: tb/maexc_unit_bench.sv
`timescale 1ns/1ps
module maexc_unit_bench;
  localparam int AW = 32;
  localparam logic [AW-1:0] VEC = 32'h0000_0080;

  typedef struct {
    logic          exc;
    logic          rte;
    logic [2:0]    psw;
    logic [2:0]    bpsw;
    logic [AW-1:0] bpc;
    logic [AW-1:0] npc;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 0, irq_req = 0, rte = 0;
  logic [1:0]    req_kind = 0;
  logic [AW-1:0] ea = 0, pc = 0;
  logic [2:0]    psw = 0;
  logic mem_en, irq_acc, exc_taken, rte_done, psw_wr;
  logic [2:0] psw_o, bpsw_o;
  logic [AW-1:0] bpc_o, npc_o;

  int n_chk = 0, n_err = 0;
  exp_t q[$];
  logic [2:0]    m_psw = 0, m_bpsw = 0;
  logic [AW-1:0] m_bpc = 0, m_npc = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  maexc_unit #(.AW(AW), .VEC_ADDR(VEC)) u_maexc_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .ea_i(ea), .pc_i(pc), .psw_i(psw), .irq_req_i(irq_req), .rte_i(rte),
    .mem_en_o(mem_en), .irq_accept_o(irq_acc), .exc_taken_o(exc_taken),
    .rte_done_o(rte_done), .psw_wr_o(psw_wr), .psw_o(psw_o), .bpsw_o(bpsw_o),
    .bpc_o(bpc_o), .next_pc_o(npc_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: apply one cycle, check combinational outputs, push registered expectation
  task automatic step(input string req, input logic v, input logic [1:0] k,
                      input logic [AW-1:0] a, input logic [AW-1:0] p,
                      input logic [2:0] s, input logic irq, input logic r);
    logic f;
    exp_t e;
    @(negedge clk);
    req_valid = v; req_kind = k; ea = a; pc = p; psw = s; irq_req = irq; rte = r;
    #1;
    f = v && ((k == 2'b10 && a[0]) || (k == 2'b11 && a[1:0] != 2'b00));
    chk(req, {31'd0, mem_en}, {31'd0, v && k != 2'b00 && !f});
    chk("R5", {31'd0, irq_acc}, {31'd0, irq && !f});
    e.exc = f;
    e.rte = r && !f;
    if (f) begin
      m_bpc = p; m_bpsw = s; m_psw = {s[2], 2'b00}; m_npc = VEC;
    end else if (r) begin
      m_psw = m_bpsw; m_npc = {m_bpc[AW-1:2], 2'b00};
    end
    e.psw = m_psw; e.bpsw = m_bpsw; e.bpc = m_bpc; e.npc = m_npc;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R6", {31'd0, exc_taken}, {31'd0, e.exc});
        chk("R9", {31'd0, rte_done}, {31'd0, e.rte});
        chk("R6", {31'd0, psw_wr}, {31'd0, e.exc | e.rte});
        chk(e.rte ? "R9" : "R6", npc_o, e.npc);
        chk(e.rte ? "R10" : "R7", {29'd0, psw_o}, {29'd0, e.psw});
        chk("R7", {29'd0, bpsw_o}, {29'd0, e.bpsw});
        chk("R8", bpc_o, e.bpc);
      end
    end
  end

  initial begin
    #100000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #12;
    // R12: reset state
    chk("R12", {31'd0, exc_taken}, 32'd0);
    chk("R12", {31'd0, rte_done}, 32'd0);
    chk("R12", npc_o, 32'd0);
    chk("R12", bpc_o, 32'd0);
    chk("R12", {26'd0, psw_o, bpsw_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1 halfword patterns
    step("R1", 1, 2'b10, 32'h100, 32'h10, 3'b111, 0, 0);
    step("R1", 1, 2'b10, 32'h102, 32'h12, 3'b111, 0, 0);
    step("R1", 1, 2'b10, 32'h101, 32'h14, 3'b111, 0, 0);
    step("R1", 1, 2'b10, 32'h103, 32'h16, 3'b011, 0, 0);
    // R2 word patterns
    step("R2", 1, 2'b11, 32'h200, 32'h20, 3'b101, 0, 0);
    step("R2", 1, 2'b11, 32'h201, 32'h24, 3'b110, 0, 0);
    step("R2", 1, 2'b11, 32'h202, 32'h26, 3'b101, 0, 0);
    step("R2", 1, 2'b11, 32'h203, 32'h28, 3'b010, 0, 0);
    // R3: byte, none, invalid never fault; R12 holds between events
    step("R3", 1, 2'b01, 32'h301, 32'h30, 3'b111, 0, 0);
    step("R3", 1, 2'b01, 32'h303, 32'h32, 3'b111, 0, 0);
    step("R4", 1, 2'b00, 32'h303, 32'h34, 3'b111, 0, 0);
    step("R3", 0, 2'b11, 32'h303, 32'h36, 3'b111, 0, 0);
    step("R3", 0, 2'b10, 32'h301, 32'h38, 3'b111, 0, 0);
    // R5: interrupt with and without a fault
    step("R4", 1, 2'b11, 32'h400, 32'h40, 3'b111, 1, 0);
    step("R5", 1, 2'b11, 32'h402, 32'h44, 3'b111, 1, 0);
    step("R5", 0, 2'b00, 32'h0, 32'h0, 3'b000, 1, 0);
    // R8/R9: fault at offset 6, return to 4
    step("R8", 1, 2'b10, 32'h501, 32'h6, 3'b111, 0, 0);
    step("R4", 0, 2'b00, 32'h0, 32'h8, 3'b000, 0, 0);
    step("R9", 0, 2'b00, 32'h0, 32'h80, 3'b000, 0, 1);
    // fault at offset 4, return to 4
    step("R8", 1, 2'b11, 32'h502, 32'h4, 3'b101, 0, 0);
    step("R10", 0, 2'b00, 32'h0, 32'h84, 3'b000, 0, 1);
    // R11: fault and return together
    step("R8", 1, 2'b11, 32'h503, 32'h1002, 3'b010, 0, 0);
    step("R11", 1, 2'b10, 32'h603, 32'h2006, 3'b100, 0, 1);
    step("R10", 0, 2'b00, 32'h0, 32'h88, 3'b000, 0, 1);
    // back-to-back faults
    step("R6", 1, 2'b11, 32'h701, 32'h3000, 3'b111, 1, 0);
    step("R6", 1, 2'b10, 32'h703, 32'h3002, 3'b001, 0, 0);
    step("R12", 0, 2'b00, 32'h0, 32'h0, 3'b000, 0, 0);
    step("R12", 0, 2'b00, 32'h0, 32'h0, 3'b000, 0, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule